// File: doc/BRIEF.md
# Glitch-Rejecting Pulse Transition Detector

The detector watches a stream of digitized waveform samples, one sample per clock when a valid strobe is high. Two programmable thresholds split the amplitude range into three bands. Each sample is graded as Low, Medium or High. A sequential recognizer then looks for genuine logic-level changes in the graded stream. An edge counts as genuine only when the waveform has settled at its old level and then settled again at its new level. In both cases "settled" means a run of `RUN_LEN` consecutive samples at that level. Any number of mid-band samples may sit between the two runs.

After reset the recognizer does not know the starting level. It stays in a startup phase until the first complete run at one level, and that run sets the level without reporting an edge. From then on, each qualifying edge produces a one-cycle pulse on `rise_pulse` or `fall_pulse`. At the same time, `det_index` is updated to the position, counted in valid samples since reset, of the sample that completed the new-level run. Short excursions to the opposite level are treated as glitches and are dropped. Cycles with the valid strobe low are ignored.

Top module: `pulse_edge_finder`

## Requirements
- R1: With `thr_lo < thr_hi`, a sample is graded Low when `smp_data <= thr_lo`, High when `smp_data >= thr_hi`, and Medium otherwise (unsigned compare).
- R2: Once the level is established as low, a run of `RUN_LEN` consecutive High samples raises `rise_pulse` for one cycle. The pulse appears in the cycle after the clock edge that accepts the `RUN_LEN`-th High sample, and the level becomes high.
- R3: Once the level is established as high, a run of `RUN_LEN` consecutive Low samples raises `fall_pulse` in the same way, and the level becomes low.
- R4: After reset no pulse is produced until a first run of `RUN_LEN` equal non-Medium samples has set the level. That first run produces no pulse, and shorter runs set nothing.
- R5: With a level established, fewer than `RUN_LEN` opposite-level samples followed by the old level produce no pulse and leave the established level unchanged.
- R6: A Medium or old-level sample inside a new-level run restarts the count, so the pulse comes only on the sample that completes an unbroken run of `RUN_LEN`.
- R7: A cycle with `smp_valid` low changes no state, counter or index, and is followed by a cycle with both pulses low.
- R8: Each pulse lasts one cycle, the two pulses are never high together, and rises and falls strictly alternate.
- R9: `det_index` is loaded together with each pulse with the 0-based count, modulo 2^`IDX_W`, of valid samples since reset that precede the detecting sample. It holds its value in all other cycles.
- R10: An asynchronous active-low reset `rst_n` clears both pulses and `det_index`, restarts the sample count at 0 and returns the recognizer to its startup phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Sample strobe; `smp_data` is taken when high |
| smp_data | input | SAMPLE_W | Unsigned waveform sample |
| thr_lo | input | SAMPLE_W | Upper bound of the Low band (inclusive) |
| thr_hi | input | SAMPLE_W | Lower bound of the High band (inclusive) |
| rise_pulse | output | 1 | One-cycle flag for a qualified up-going edge |
| fall_pulse | output | 1 | One-cycle flag for a qualified down-going edge |
| det_index | output | IDX_W | Sample position of the latest detection |

## Verification
The checker grades samples from the ports itself, so it relies on `thr_lo` being strictly below `thr_hi`. It also relies on both thresholds staying constant between resets, because its run counters would otherwise mix samples graded against different bands. The bench fixes the thresholds at 60 and 180 for the whole run. Its data values are chosen either well inside a band or exactly on the band edges 60, 61, 179 and 180. Invalid cycles carry deliberately misleading data, which tests that such cycles are ignored without breaking the checker's assumptions.

// File: rtl/pef_pkg.sv
package pef_pkg;

  typedef enum logic [1:0] {
    SYM_LO  = 2'd0,
    SYM_MID = 2'd1,
    SYM_HI  = 2'd2
  } sym_e;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2
  } phase_e;

endpackage

// File: rtl/pef_classify.sv
module pef_classify
  import pef_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic [SAMPLE_W-1:0] lo_i,
  input  logic [SAMPLE_W-1:0] hi_i,
  output sym_e                sym_o
);

  // Low band is tested first, so an overlapping threshold pair grades as Low.
  always_comb begin
    if (data_i <= lo_i)      sym_o = SYM_LO;
    else if (data_i >= hi_i) sym_o = SYM_HI;
    else                     sym_o = SYM_MID;
  end

endmodule

// File: rtl/pef_recognizer.sv
module pef_recognizer
  import pef_pkg::*;
#(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  sym_e sym_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int CW = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  phase_e        phase_q, phase_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          seed_hi_q, seed_hi_n;
  logic [CW-1:0] run;
  logic          is_hi;

  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    seed_hi_n = seed_hi_q;
    rise_o    = 1'b0;
    fall_o    = 1'b0;
    is_hi     = (sym_i == SYM_HI);
    run       = '0;
    if (en_i) begin
      unique case (phase_q)
        PH_START: begin
          if (sym_i == SYM_MID) begin
            cnt_n = '0;
          end else begin
            if ((cnt_q != '0) && (seed_hi_q == is_hi)) run = cnt_q + CW'(1);
            else                                       run = CW'(1);
            if (run == FULL) begin
              phase_n = is_hi ? PH_HIGH : PH_LOW;
              cnt_n   = '0;
            end else begin
              cnt_n     = run;
              seed_hi_n = is_hi;
            end
          end
        end
        PH_LOW: begin
          if (sym_i == SYM_HI) begin
            if (cnt_q == LAST) begin
              rise_o  = 1'b1;
              phase_n = PH_HIGH;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end else begin
            cnt_n = '0;
          end
        end
        PH_HIGH: begin
          if (sym_i == SYM_LO) begin
            if (cnt_q == LAST) begin
              fall_o  = 1'b1;
              phase_n = PH_LOW;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end else begin
            cnt_n = '0;
          end
        end
        default: begin
          phase_n = PH_START;
          cnt_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_START;
      cnt_q     <= '0;
      seed_hi_q <= 1'b0;
    end else if (en_i) begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      seed_hi_q <= seed_hi_n;
    end
  end

endmodule

// File: rtl/pef_index_ctr.sv
module pef_index_ctr #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] idx_q, idx_n;

  always_comb idx_n = idx_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (en_i) idx_q <= idx_n;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/pulse_edge_finder.sv
module pulse_edge_finder
  import pef_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int RUN_LEN  = 3,
  parameter int IDX_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] thr_lo,
  input  logic [SAMPLE_W-1:0] thr_hi,
  output logic                rise_pulse,
  output logic                fall_pulse,
  output logic [IDX_W-1:0]    det_index
);

  sym_e             sym;
  logic             hit_rise, hit_fall;
  logic [IDX_W-1:0] cur_idx;
  logic             rise_q, fall_q;
  logic [IDX_W-1:0] det_q, det_n;
  logic             det_en;

  pef_classify #(.SAMPLE_W(SAMPLE_W)) u_cls (
    .data_i (smp_data),
    .lo_i   (thr_lo),
    .hi_i   (thr_hi),
    .sym_o  (sym)
  );

  pef_recognizer #(.RUN_LEN(RUN_LEN)) u_rec (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (smp_valid),
    .sym_i  (sym),
    .rise_o (hit_rise),
    .fall_o (hit_fall)
  );

  pef_index_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (smp_valid),
    .idx_o (cur_idx)
  );

  always_comb begin
    det_en = hit_rise | hit_fall;
    det_n  = cur_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= hit_rise;
      fall_q <= hit_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      det_q <= '0;
    else if (det_en) det_q <= det_n;
  end

  assign rise_pulse = rise_q;
  assign fall_pulse = fall_q;
  assign det_index  = det_q;

endmodule

// File: rtl/pulse_edge_finder_chk.sv
module pulse_edge_finder_chk #(
  parameter int SAMPLE_W = 8,
  parameter int RUN_LEN  = 3,
  parameter int IDX_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [SAMPLE_W-1:0] thr_lo,
  input logic [SAMPLE_W-1:0] thr_hi,
  input logic                rise_pulse,
  input logic                fall_pulse,
  input logic [IDX_W-1:0]    det_index
);

  localparam int CW = $clog2(RUN_LEN + 2);
  localparam logic [CW-1:0] SAT = CW'(RUN_LEN);

  logic [CW-1:0] hi_run, lo_run;
  logic          any_edge, last_up;
  logic          s_lo, s_hi;

  always_comb begin
    s_lo = (smp_data <= thr_lo);
    s_hi = !s_lo && (smp_data >= thr_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (smp_valid) begin
      hi_run <= s_hi ? ((hi_run == SAT) ? SAT : hi_run + CW'(1)) : '0;
      lo_run <= s_lo ? ((lo_run == SAT) ? SAT : lo_run + CW'(1)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_edge <= 1'b0;
      last_up  <= 1'b0;
    end else if (rise_pulse || fall_pulse) begin
      any_edge <= 1'b1;
      last_up  <= rise_pulse;
    end
  end

  // R8
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));

  // R8
  edges_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pulse && any_edge) |-> !last_up);

  // R8
  falls_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pulse && any_edge) |-> last_up);

  // R7
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!rise_pulse && !fall_pulse));

  // R9
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_pulse && !fall_pulse) |-> $stable(det_index));

  // R2
  rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> (hi_run == SAT));

  // R3
  fall_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> (lo_run == SAT));

endmodule

bind pulse_edge_finder pulse_edge_finder_chk #(
  .SAMPLE_W (SAMPLE_W),
  .RUN_LEN  (RUN_LEN),
  .IDX_W    (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .thr_lo     (thr_lo),
  .thr_hi     (thr_hi),
  .rise_pulse (rise_pulse),
  .fall_pulse (fall_pulse),
  .det_index  (det_index)
);

// File: tb/pulse_edge_finder_tb.sv
module pulse_edge_finder_tb;

  localparam int SW  = 8;
  localparam int P   = 3;
  localparam int IW  = 5;
  localparam int LOT = 60;
  localparam int HIT = 180;
  localparam int SL  = 0;
  localparam int SM  = 1;
  localparam int SH  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [SW-1:0] smp_data;
  logic [SW-1:0] thr_lo, thr_hi;
  logic          rise_pulse, fall_pulse;
  logic [IW-1:0] det_index;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int hist [0:4095];
  int n_smp;
  int exp_idx;

  always #5 clk = ~clk;

  pulse_edge_finder #(.SAMPLE_W(SW), .RUN_LEN(P), .IDX_W(IW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .thr_lo     (thr_lo),
    .thr_hi     (thr_hi),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .det_index  (det_index)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int grade(input int d);
    if (d <= LOT)      return SL;
    else if (d >= HIT) return SH;
    else               return SM;
  endfunction

  function automatic int amp(input int s);
    if (s == SL)      return 20;
    else if (s == SM) return 120;
    else              return 220;
  endfunction

  // level of the latest complete equal run ending at or before e, -1 if none
  function automatic int level_before(input int e);
    for (int j = e; j >= P - 1; j--) begin
      bit same = (hist[j] != SM);
      for (int k = 1; k < P; k++) if (hist[j-k] != hist[j]) same = 1'b0;
      if (same) return hist[j];
    end
    return -1;
  endfunction

  // sample i completes exactly P of symbol s
  function automatic bit run_done(input int i, input int s);
    if (i < P - 1) return 1'b0;
    for (int k = 0; k < P; k++) if (hist[i-k] != s) return 1'b0;
    if (i >= P && hist[i-P] == s) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    @(posedge clk);
    #1;
    chk(rise_pulse == 1'b0 && fall_pulse == 1'b0, "R10", "pulses in reset",
        {rise_pulse, fall_pulse}, 0);
    chk(det_index == '0, "R10", "index in reset", det_index, 0);
    @(negedge clk);
    rst_n   = 1'b1;
    n_smp   = 0;
    exp_idx = 0;
  endtask

  task automatic step(input int d, input string tag);
    int  s;
    bit  er, ef;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = SW'(d);
    @(posedge clk);
    #1;
    s           = grade(d);
    hist[n_smp] = s;
    er = run_done(n_smp, SH) && (level_before(n_smp - P) == SL);
    ef = run_done(n_smp, SL) && (level_before(n_smp - P) == SH);
    if (er || ef) exp_idx = n_smp % (1 << IW);
    chk(rise_pulse == er, (tag == "") ? "R2" : tag, "rise_pulse", rise_pulse, er);
    chk(fall_pulse == ef, (tag == "") ? "R3" : tag, "fall_pulse", fall_pulse, ef);
    chk(!(rise_pulse && fall_pulse), "R8", "both pulses", 1, 0);
    chk(int'(det_index) == exp_idx, "R9", "det_index", det_index, exp_idx);
    n_smp++;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int d);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = SW'(d);
    @(posedge clk);
    #1;
    chk(!rise_pulse && !fall_pulse, "R7", "pulse after idle",
        {rise_pulse, fall_pulse}, 0);
    chk(int'(det_index) == exp_idx, "R7", "index after idle", det_index, exp_idx);
  endtask

  task automatic seq(input int syms[], input string tag);
    foreach (syms[i]) step(amp(syms[i]), tag);
  endtask

  initial begin
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    thr_lo    = SW'(LOT);
    thr_hi    = SW'(HIT);
    n_smp     = 0;
    exp_idx   = 0;

    do_reset();

    // R1: band edges 60 -> Low, 180 -> High, 61 and 179 -> Medium
    step(60, "R1"); step(60, "R1"); step(60, "R1");
    step(61, "R1"); step(179, "R1");
    step(180, "R1"); step(180, "R1"); step(180, "R1");
    step(179, "R1"); step(61, "R1");
    step(60, "R1"); step(60, "R1"); step(60, "R1");

    // R4: short runs in startup set nothing, first full run gives no pulse
    do_reset();
    seq('{SH, SH, SM, SL, SL, SH, SL, SL, SL}, "R4");
    seq('{SM, SH, SH, SH}, "R4");

    // R5: glitch of P-1 highs from low level, level kept low
    do_reset();
    seq('{SL, SL, SL, SH, SH, SL, SH, SH, SM, SL, SM, SH, SH, SH}, "R5");

    // R6: Medium or old level breaks the new-level run
    do_reset();
    seq('{SH, SH, SH, SL, SL, SM, SL, SL, SH, SL, SL, SL}, "R6");

    // R7: invalid cycles with misleading data change nothing
    do_reset();
    seq('{SL, SL, SL, SH, SH}, "R7");
    idle(220); idle(220); idle(20);
    step(amp(SH), "R7");
    idle(20); idle(20); idle(20);
    seq('{SL, SL}, "R7");
    idle(220);
    step(amp(SL), "R7");

    // R9: index wraps past 2^IW over a long alternating stream
    do_reset();
    for (int r = 0; r < 12; r++) begin
      seq('{SL, SL, SL}, "R9");
      seq('{SH, SH, SH}, "R9");
    end

    // R10: reset mid-stream restarts startup and the sample count
    seq('{SL, SL}, "R10");
    do_reset();
    seq('{SH, SH, SH, SL, SL, SL}, "R10");

    // R2 R3 R4 R5 R6 R7: every sequence of 7 symbols, odd ones with idle gaps
    for (int s = 0; s < 2187; s++) begin
      int v = s;
      do_reset();
      for (int k = 0; k < 7; k++) begin
        step(amp(v % 3), "");
        v = v / 3;
        if ((s % 2 == 1) && k < 6) idle((k % 2 == 0) ? 220 : 20);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule